// File: doc/BRIEF.md
# Serial Real-Time-Clock Command Sequencer

This block drives a serial real-time-clock chip whose interface consists of a 3-bit command code, a command strobe, a serial data line into the chip, a shift clock and a serial data line out of the chip. It turns two one-cycle requests into complete pin sequences. A set request captures a 40-bit date/time word, puts the chip into shift mode, clocks the word out least significant bit first, and then issues the commit command. A read request makes the chip latch its time, puts it into shift mode, and clocks 40 bits back. The block also watches the chip's periodic 4 ms square wave and turns each rising edge into a one-cycle scan tick, whether or not a sequence is running.

Each command places its code on the code pins one cycle before the strobe rises. The strobe stays high for `STB_HI` cycles, and the code is held for one more cycle after the strobe falls. During a shift, each bit stays low for `HALF` cycles and then high for `HALF` cycles. Outgoing data changes only at the falling edge of the shift clock. Incoming data is sampled in the last low cycle before each rising edge.

Top module: `rtc_seq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `cmd_stb`, `sclk`, `rd_valid` and `scan_tick` are 0 and `cmd_code` is 3'b000. A request held during reset produces no strobe.
- R2: `cmd_code` is stable throughout every strobe pulse, and each strobe is high for exactly `STB_HI` cycles. Code values are given with `cmd_code[0]` as the first code pin: shift mode = 3'b001, commit time = 3'b010, latch time for read = 3'b011.
- R3: A set request produces this sequence: a strobe with code 3'b001, then 40 shift-clock rising edges, then a strobe with code 3'b010. The chip captures bit i of `set_word` at the i-th rising edge (LSB first).
- R4: A read request produces this sequence: a strobe with code 3'b011, then a strobe with code 3'b001, then 40 shift-clock pulses. `sdat_in` sampled before the i-th rising edge appears in bit i of `rd_word`. When the sequence ends, `rd_valid` is high for exactly one cycle, and it is never high while `busy` is high.
- R5: Each shift-clock high phase and each low phase between pulses lasts exactly `HALF` cycles. `sdat_out` never changes while `sclk` is high.
- R6: `busy` rises in the cycle after a request is accepted and stays high until the sequence ends. `cmd_stb` and `sclk` are high only while `busy` is high.
- R7: Requests that arrive while `busy` is high are ignored: no extra strobe and no change to the word being shifted.
- R8: When `set_req` and `read_req` are high in the same idle cycle, the set sequence runs.
- R9: `scan_tick` is high for exactly one cycle for each rising edge of `tp_in`. Ticks are produced during sequences as well, and a level held high gives only one tick.
- R10: `cmd_stb` and `sclk` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_req | input | 1 | One-cycle request to write a new time |
| read_req | input | 1 | One-cycle request to read the time |
| set_word | input | WORD_W | Date/time word captured with `set_req` |
| busy | output | 1 | A sequence is in progress |
| rd_valid | output | 1 | One-cycle pulse when a read sequence finishes |
| rd_word | output | WORD_W | Word read back; holds until the next set is accepted |
| cmd_code | output | 3 | Command code pins to the chip |
| cmd_stb | output | 1 | Command strobe to the chip |
| sclk | output | 1 | Shift clock to the chip |
| sdat_out | output | 1 | Serial data into the chip |
| sdat_in | input | 1 | Serial data out of the chip |
| tp_in | input | 1 | Periodic square wave from the chip (asynchronous) |
| scan_tick | output | 1 | One-cycle tick per rising edge of `tp_in` |

## Verification
Two pairs of functions can coincide. A rising edge of `tp_in` can arrive in the middle of a 40-bit shift, and both requests can arrive in the same idle cycle. The bench toggles `tp_in` several times while a set sequence is shifting. It then requires the tick count to equal the number of edges and the shifted word and command log to be intact. For the second case, it raises `set_req` and `read_req` together and requires a logged code order of shift then commit, with the captured word equal to `set_word`.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSET,
      ST_CSTB,
      ST_CREL,
      ST_LO,
      ST_HI
   } seq_st_t;

   localparam logic [2:0] CODE_SHIFT = 3'b001;
   localparam logic [2:0] CODE_TSET  = 3'b010;
   localparam logic [2:0] CODE_TREAD = 3'b011;

   // Each sequence has three steps; one of them is the serial shift.
   function automatic logic step_is_cmd(input logic rd, input logic [1:0] s);
      return rd ? (s != 2'd2) : (s != 2'd1);
   endfunction

   function automatic logic [2:0] step_code(input logic rd, input logic [1:0] s);
      if (rd) return (s == 2'd0) ? CODE_TREAD : CODE_SHIFT;
      return (s == 2'd0) ? CODE_SHIFT : CODE_TSET;
   endfunction

endpackage

// File: rtl/rtc_tick_edge.sv
module rtc_tick_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tp_in,
   output logic tick
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_tick_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], tp_in};
         last_q <= sync_q[STAGES-1];
         tick_q <= sync_q[STAGES-1] & ~last_q;
      end
   end

   assign tick = tick_q;

   assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);
endmodule

// File: rtl/rtc_shreg.sv
module rtc_shreg #(
   parameter int WIDTH     = 40,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             sample,
   input  logic             shift,
   input  logic             ser_in,
   output logic             ser_out,
   output logic [WIDTH-1:0] par_out
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("rtc_shreg: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] q;
   logic             samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q <= 1'b0;
      else if (sample) samp_q <= ser_in;
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (load) q <= load_val;
            else if (shift) q <= {samp_q, q[WIDTH-1:1]};
         end
         assign ser_out = q[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (load) q <= load_val;
            else if (shift) q <= {q[WIDTH-2:0], samp_q};
         end
         assign ser_out = q[WIDTH-1];
      end
   endgenerate

   assign par_out = q;
endmodule

// File: rtl/rtc_seq_top.sv
module rtc_seq_top
   import rtc_seq_pkg::*;
#(
   parameter int WORD_W      = 40,
   parameter int STB_HI      = 4,
   parameter int HALF        = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_req,
   input  logic              read_req,
   input  logic [WORD_W-1:0] set_word,
   output logic              busy,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_word,
   output logic [2:0]        cmd_code,
   output logic              cmd_stb,
   output logic              sclk,
   output logic              sdat_out,
   input  logic              sdat_in,
   input  logic              tp_in,
   output logic              scan_tick
);
   localparam int MAXC  = (STB_HI > HALF) ? STB_HI : HALF;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int BIT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_HI - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
   localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

   generate
      if (STB_HI < 1) begin : g_bad_stb
         $error("rtc_seq_top: STB_HI must be at least 1");
      end
      if (HALF < 1) begin : g_bad_half
         $error("rtc_seq_top: HALF must be at least 1");
      end
   endgenerate

   seq_st_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic [1:0]       step_q;
   logic             op_rd_q;
   logic [2:0]       code_q;
   logic             rdv_q;

   logic       idle, req, step_done, seq_end, enter;
   logic       nx_rd, nx_cmd, load_en, sample_en, shift_en;
   logic [1:0] nx_step;
   logic [2:0] nx_code;

   always_comb begin
      idle      = (st_q == ST_IDLE);
      req       = set_req | read_req;
      step_done = (st_q == ST_CREL) ||
                  (st_q == ST_HI && cnt_q == HALF_LAST && bit_q == BIT_LAST);
      seq_end   = step_done && (step_q == 2'd2);
      nx_rd     = idle ? ~set_req : op_rd_q;
      nx_step   = idle ? 2'd0 : step_q + 2'd1;
      enter     = (idle && req) || (step_done && !seq_end);
      nx_cmd    = step_is_cmd(nx_rd, nx_step);
      nx_code   = step_code(nx_rd, nx_step);
      load_en   = idle && set_req;
      sample_en = (st_q == ST_LO) && (cnt_q == HALF_LAST);
      shift_en  = (st_q == ST_HI) && (cnt_q == HALF_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         step_q  <= 2'd0;
         op_rd_q <= 1'b0;
         code_q  <= 3'b000;
         rdv_q   <= 1'b0;
      end else begin
         rdv_q <= 1'b0;
         case (st_q)
            ST_CSET: begin
               st_q  <= ST_CSTB;
               cnt_q <= '0;
            end
            ST_CSTB: begin
               if (cnt_q == STB_LAST) begin
                  st_q  <= ST_CREL;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_LO: begin
               if (cnt_q == HALF_LAST) begin
                  st_q  <= ST_HI;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            ST_HI: begin
               if (cnt_q == HALF_LAST) begin
                  st_q  <= ST_LO;
                  cnt_q <= '0;
                  bit_q <= bit_q + 1'b1;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: ;
         endcase
         if (enter) begin
            st_q    <= nx_cmd ? ST_CSET : ST_LO;
            cnt_q   <= '0;
            bit_q   <= '0;
            step_q  <= nx_step;
            op_rd_q <= nx_rd;
            if (nx_cmd) code_q <= nx_code;
         end
         if (seq_end) begin
            st_q  <= ST_IDLE;
            rdv_q <= op_rd_q;
         end
      end
   end

   rtc_shreg #(.WIDTH(WORD_W), .LSB_FIRST(LSB_FIRST)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_en),
      .load_val (set_word),
      .sample   (sample_en),
      .shift    (shift_en),
      .ser_in   (sdat_in),
      .ser_out  (sdat_out),
      .par_out  (rd_word)
   );

   rtc_tick_edge #(.STAGES(SYNC_STAGES)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tp_in (tp_in),
      .tick  (scan_tick)
   );

   assign busy     = ~idle;
   assign cmd_stb  = (st_q == ST_CSTB);
   assign sclk     = (st_q == ST_HI);
   assign cmd_code = code_q;
   assign rd_valid = rdv_q;

   assert_code_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $stable(cmd_code));
   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdat_out));
   assert_pins_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb || sclk) |-> busy);
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stb && sclk));
   assert_rdvalid_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy);
   assert_busy_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_end) |=> busy);
endmodule

// File: tb/tb_rtc_seq_top.sv
module tb_rtc_seq_top;
   localparam int W  = 40;
   localparam int SH = 3;
   localparam int HF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic set_req = 1'b0, read_req = 1'b0;
   logic [W-1:0] set_word = '0;
   logic busy, rd_valid, cmd_stb, sclk, sdat_out, scan_tick;
   logic [W-1:0] rd_word;
   logic [2:0] cmd_code;
   logic sdat_in = 1'b0;
   logic tp_in = 1'b0;

   always #5 clk = ~clk;

   rtc_seq_top #(.WORD_W(W), .STB_HI(SH), .HALF(HF)) dut (
      .clk(clk), .rst_n(rst_n), .set_req(set_req), .read_req(read_req),
      .set_word(set_word), .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word),
      .cmd_code(cmd_code), .cmd_stb(cmd_stb), .sclk(sclk), .sdat_out(sdat_out),
      .sdat_in(sdat_in), .tp_in(tp_in), .scan_tick(scan_tick)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // chip model
   logic [2:0]   log_c [8];
   int           n_log = 0;
   logic [W-1:0] wcap = '0;
   logic [W-1:0] rmodel = '0;
   int           n_pulse = 0;
   int           ridx = 0;

   always @(posedge cmd_stb) begin
      if (n_log < 8) log_c[n_log] = cmd_code;
      n_log++;
      if (cmd_code == 3'b001) begin
         ridx = 0;
         sdat_in = rmodel[0];
      end
   end

   always @(posedge sclk) begin
      wcap = {sdat_out, wcap[W-1:1]};
      n_pulse++;
      ridx++;
      if (ridx < W) sdat_in = rmodel[ridx];
   end

   // pin-timing monitor, sampled on falling edge
   int stb_run = 0, stb_min = 999, stb_max = 0;
   int hi_run = 0, hi_min = 999, hi_max = 0;
   int lo_run = 0, lo_min = 999, lo_max = 0;
   int n_tick = 0, n_rdv = 0;
   logic prev_sclk = 1'b0;

   always @(negedge clk) begin
      if (scan_tick) n_tick++;
      if (rd_valid) n_rdv++;
      if (cmd_stb) stb_run++;
      else if (stb_run > 0) begin
         if (stb_run < stb_min) stb_min = stb_run;
         if (stb_run > stb_max) stb_max = stb_run;
         stb_run = 0;
      end
      if (sclk) begin
         if (!prev_sclk && lo_run > 0) begin
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
         end
         lo_run = 0;
         hi_run++;
      end else begin
         if (prev_sclk) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            lo_run = 1;
         end else if (lo_run > 0) lo_run++;
         hi_run = 0;
      end
      if (!busy) lo_run = 0;
      prev_sclk = sclk;
   end

   task automatic clear_logs();
      n_log = 0; n_pulse = 0; n_rdv = 0; wcap = '0;
      stb_min = 999; stb_max = 0; hi_min = 999; hi_max = 0;
      lo_min = 999; lo_max = 0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic issue(input bit s, input bit r, input logic [W-1:0] w,
                        input logic [W-1:0] rm);
      @(negedge clk);
      clear_logs();
      rmodel = rm;
      set_word = w;
      set_req = s;
      read_req = r;
      @(negedge clk);
      set_req = 1'b0;
      read_req = 1'b0;
   endtask

   // {is_read, word to set, word the chip returns}
   localparam logic [2*W:0] VEC [5] = '{
      {1'b0, 40'h12_3456_789A, 40'h00_0000_0000},
      {1'b1, 40'h00_0000_0000, 40'hA5_0F3C_96E1},
      {1'b0, 40'h80_0000_0001, 40'h00_0000_0000},
      {1'b1, 40'h00_0000_0000, 40'h80_0000_0001},
      {1'b0, 40'hFF_FFFF_FFFE, 40'h00_0000_0000}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 / reset: request held during reset does nothing
      set_req = 1'b1;
      set_word = 40'h11_1111_1111;
      repeat (5) @(negedge clk);
      check(!busy && !cmd_stb && !sclk && !rd_valid && !scan_tick && cmd_code == 3'b000,
            "R1 outputs in reset", {busy, cmd_stb, sclk, rd_valid, scan_tick, cmd_code}, 0);
      set_req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && cmd_code == 3'b000, "R1 after release", {busy, cmd_code}, 0);
      repeat (5) @(negedge clk);
      check(n_log == 0, "R1 no strobe from reset-time request", n_log, 0);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < 5; i++) begin
         logic        rd;
         logic [W-1:0] sw, rw;
         rd = VEC[i][2*W];
         sw = VEC[i][2*W-1:W];
         rw = VEC[i][W-1:0];
         issue(!rd, rd, sw, rw);
         check(busy, "R6 busy after accept", busy, 1);
         wait_done();
         check(n_log == 2, "R3/R4 strobe count", n_log, 2);
         if (rd) begin
            check(log_c[0] == 3'b011 && log_c[1] == 3'b001, "R4 code order",
                  {log_c[0], log_c[1]}, 6'o31);
            check(rd_valid, "R4 rd_valid at end", rd_valid, 1);
            check(rd_word == rw, "R4 read word", rd_word, rw);
         end else begin
            check(log_c[0] == 3'b001 && log_c[1] == 3'b010, "R3 code order",
                  {log_c[0], log_c[1]}, 6'o12);
            check(wcap == sw, "R3 shifted word", wcap, sw);
         end
         check(n_pulse == W, "R3/R4 shift pulses", n_pulse, W);
         check(stb_min == SH && stb_max == SH, "R2 strobe width", {stb_min, stb_max},
               {SH, SH});
         check(hi_min == HF && hi_max == HF && lo_min == HF && lo_max == HF,
               "R5 shift clock phases", {hi_min, hi_max, lo_min, lo_max},
               {HF, HF, HF, HF});
         repeat (3) @(negedge clk);
         check(n_rdv == (rd ? 1 : 0), "R4 rd_valid pulse count", n_rdv, rd);
      end

      // R7: requests while busy are ignored
      issue(1'b1, 1'b0, 40'h0F_0F0F_0F0F, '0);
      repeat (8) @(negedge clk);
      set_word = 40'hFF_FFFF_FFFF;
      read_req = 1'b1;
      set_req = 1'b1;
      @(negedge clk);
      read_req = 1'b0;
      set_req = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      check(n_log == 2, "R7 no extra strobes", n_log, 2);
      check(wcap == 40'h0F_0F0F_0F0F, "R7 word untouched", wcap, 40'h0F_0F0F_0F0F);

      // R8: simultaneous requests, set wins
      issue(1'b1, 1'b1, 40'h3C_A55A_C33C, 40'hFF_FFFF_FFFF);
      wait_done();
      check(log_c[0] == 3'b001 && log_c[1] == 3'b010, "R8 set sequence chosen",
            {log_c[0], log_c[1]}, 6'o12);
      check(wcap == 40'h3C_A55A_C33C, "R8 set word", wcap, 40'h3C_A55A_C33C);
      check(n_rdv == 0, "R8 no rd_valid", n_rdv, 0);

      // R9: ticks during a shift, and a held level
      n_tick = 0;
      issue(1'b1, 1'b0, 40'h55_AA55_AA55, '0);
      for (int k = 0; k < 3; k++) begin
         repeat (10) @(negedge clk);
         tp_in = 1'b1;
         repeat (10) @(negedge clk);
         tp_in = 1'b0;
      end
      wait_done();
      repeat (6) @(negedge clk);
      check(n_tick == 3, "R9 ticks during shift", n_tick, 3);
      check(wcap == 40'h55_AA55_AA55, "R9 shift intact with ticks", wcap,
            40'h55_AA55_AA55);
      n_tick = 0;
      tp_in = 1'b1;
      repeat (40) @(negedge clk);
      check(n_tick == 1, "R9 held level one tick", n_tick, 1);
      tp_in = 1'b0;
      repeat (5) @(negedge clk);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule